// File: doc/BRIEF.md
# Single-Wire Identity Responder

This block is the slave side of a single open-drain data line shared with one bus master. It holds a fixed 64-bit identity supplied as a parameter. Its inputs are a clock and the sampled line level. Its only output asks the pad to pull the line low. All bus timing is derived by counting clock cycles, and every duration is computed from the `CLK_HZ` parameter.

When the master holds the line low long enough, the block treats this as a bus reset. After the line is released, it waits and then answers with a presence pulse. Next it takes in an 8-bit command. Depending on that command, it does one of three things:

- it streams its identity out;
- it takes part in the bit-by-bit elimination search that lets a master enumerate several slaves on one line;
- it falls silent until the next reset.

Identity bit 0 goes out first. Bits [7:0] hold the family code 01h, bits [55:8] hold the serial number, and bits [63:56] hold the check byte. The line is wired-AND, so a slave that answers a 0 overrides the master's released level.

The state machine has nine states. Their transitions are as follows:

- `ST_IDLE` is silent and leaves only through a reset.
- `ST_RESET` is entered from any state once the line has been low for 480 µs. It moves to `ST_PD_WAIT` when the line goes high.
- `ST_PD_WAIT` moves to `ST_PD_DRIVE` after 30 µs.
- `ST_PD_DRIVE` pulls the line low for 120 µs and then moves to `ST_CMD`.
- `ST_CMD` samples eight bits. After the eighth bit it goes to `ST_READ` on 33h or 0Fh, to `ST_SRCH_BIT` on F0h, and to `ST_IDLE` on any other value.
- `ST_READ` returns to `ST_IDLE` after bit 63.
- In the search, `ST_SRCH_BIT` moves to `ST_SRCH_CMP`, and `ST_SRCH_CMP` moves to `ST_SRCH_DIR`.
- `ST_SRCH_DIR` returns to `ST_SRCH_BIT` when the master's bit matches the slave's bit. It goes to `ST_IDLE` on a mismatch or after bit 63.

Top module: `ow_id_slave`

## Requirements
- R1: A line level held low for at least 480 µs is taken as a bus reset. A low of 400 µs, or a slot issued without any earlier reset, produces no response.
- R2: After a reset, once the line rises, the block keeps the line released for 30 µs and then pulls it low for 120 µs. At 15 µs and at 200 µs after the release the line is high; at 70 µs it is low.
- R3: The command byte is taken least significant bit first, one bit per master slot. Each bit is sampled 30 µs after the slot's falling edge, so a master low time of 15 µs or less reads as 1 and one of 60 µs or more reads as 0. Code 0Fh therefore reads the identity and is not taken as F0h.
- R4: After command 33h or 0Fh, the block sends the 64 identity bits in the order bit 0 to bit 63, one per master-started slot.
- R5: To send a 0, the block pulls the line low from the slot's falling edge until about 15 µs after it, so the line is low at 12 µs and high at 25 µs. To send a 1, it leaves the line released.
- R6: Commands 55h and CCh, and every code other than 33h, 0Fh and F0h, leave the line released in all later slots until the next reset. Directly after the block's own reset it is silent too.
- R7: After command F0h, for each bit i from 0 to 63 the block sends bit i, then the complement of bit i, then samples the master's chosen bit.
- R8: During a search, if the master's chosen bit differs from identity bit i, the block stays released until the next reset.
- R9: A reset that arrives while a command or data transfer is in progress aborts it. The block restarts with a presence pulse and takes a new command.
- R10: After the last identity bit of a read or of a full search, the block stays released until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at `CLK_HZ` |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sampled level of the shared data line |
| pull_low_o | output | 1 | 1 requests the pad to pull the line low |

## Verification
The bench builds the block with `CLK_HZ` set to 2 MHz, so one microsecond is two cycles. At this setting a full identity read, a complete 64-bit search and a reset arriving in the middle of a read all fit within the run. The timing margins are still resolved finely enough to show the 15 µs hold edge and the 30 µs sample point. The identity parameter is a non-trivial value with mixed ones and zeros, so every bit position, its complement and a drop-out after a randomly chosen search bit are all observed at the line.

// File: rtl/ow_id_pkg.sv
package ow_id_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RESET,
        ST_PD_WAIT,
        ST_PD_DRIVE,
        ST_CMD,
        ST_READ,
        ST_SRCH_BIT,
        ST_SRCH_CMP,
        ST_SRCH_DIR
    } ow_state_e;

    localparam logic [7:0] CMD_READ_A = 8'h33;
    localparam logic [7:0] CMD_READ_B = 8'h0F;
    localparam logic [7:0] CMD_SEARCH = 8'hF0;

    // Convert microseconds to clock ticks for a given clock frequency.
    function automatic int us_ticks(input int clk_hz, input int us);
        return (clk_hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/ow_line_sync.sv
// Synchronises the line, flags falling edges and reports a long low level.
module ow_line_sync #(
    parameter int RST_T = 960,
    parameter int TW    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s_o,
    output logic fall_o,
    output logic rst_long_o
);

    logic [1:0]    sync_q;
    logic          prev_q;
    logic [TW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
            low_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], line_i};
            prev_q <= sync_q[1];
            if (sync_q[1]) begin
                low_q <= '0;
            end else if (low_q != TW'(RST_T)) begin
                low_q <= low_q + 1'b1;
            end
        end
    end

    assign line_s_o   = sync_q[1];
    assign fall_o     = prev_q & ~sync_q[1];
    assign rst_long_o = ~sync_q[1] && (low_q == TW'(RST_T));

endmodule

// File: rtl/ow_slot_timer.sv
// Counts from each falling edge; gives the sample strobe and the hold window.
module ow_slot_timer #(
    parameter int SAMPLE_T = 60,
    parameter int HOLD_T   = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    output logic sample_stb_o,
    output logic hold_win_o
);

    localparam int SW = $clog2(SAMPLE_T + 2);

    logic [SW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (fall_i) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q && cnt_q != SW'(SAMPLE_T + 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sample_stb_o = run_q && (cnt_q == SW'(SAMPLE_T));
    assign hold_win_o   = run_q && (cnt_q < SW'(HOLD_T));

endmodule

// File: rtl/ow_id_rom_bit.sv
// Selects one identity bit, optionally complemented for the search step.
module ow_id_rom_bit #(
    parameter int          ID_W   = 64,
    parameter int          IDX_W  = 6,
    parameter logic [63:0] ROM_ID = 64'h0
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             invert_i,
    output logic             bit_o
);

    logic [ID_W-1:0] rom;
    assign rom   = ROM_ID[ID_W-1:0];
    assign bit_o = rom[idx_i] ^ invert_i;

endmodule

// File: rtl/ow_id_slave.sv
module ow_id_slave
    import ow_id_pkg::*;
#(
    parameter int          CLK_HZ = 50_000_000,
    parameter logic [63:0] ROM_ID = 64'hA200_000B_ADC0_DE01
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic pull_low_o
);

    localparam int ID_W      = 64;
    localparam int IDX_W     = $clog2(ID_W);
    localparam int RST_T     = us_ticks(CLK_HZ, 480);
    localparam int PD_WAIT_T = us_ticks(CLK_HZ, 30);
    localparam int PD_LEN_T  = us_ticks(CLK_HZ, 120);
    localparam int SAMPLE_T  = us_ticks(CLK_HZ, 30);
    localparam int HOLD_T    = us_ticks(CLK_HZ, 15);
    localparam int TW        = $clog2(RST_T + 1);

    ow_state_e        state_q, state_d;
    logic             line_s, fall, rst_long;
    logic             sample_stb, hold_win;
    logic             own_bit;
    logic [TW-1:0]    dly_q;
    logic [7:0]       cmd_sr_q;
    logic [7:0]       cmd_word;
    logic [2:0]       cmd_cnt_q;
    logic [IDX_W-1:0] bit_idx_q;

    ow_line_sync #(.RST_T(RST_T), .TW(TW)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_i),
        .line_s_o  (line_s),
        .fall_o    (fall),
        .rst_long_o(rst_long)
    );

    ow_slot_timer #(.SAMPLE_T(SAMPLE_T), .HOLD_T(HOLD_T)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_i      (fall),
        .sample_stb_o(sample_stb),
        .hold_win_o  (hold_win)
    );

    ow_id_rom_bit #(.ID_W(ID_W), .IDX_W(IDX_W), .ROM_ID(ROM_ID)) u_rom (
        .idx_i   (bit_idx_q),
        .invert_i(state_q == ST_SRCH_CMP),
        .bit_o   (own_bit)
    );

    // Incoming bit is shifted in at the top: least significant bit first.
    assign cmd_word = {line_s, cmd_sr_q[7:1]};

    // Next-state logic; a long low level overrides every state.
    always_comb begin
        state_d = state_q;
        if (rst_long) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RESET: if (line_s) state_d = ST_PD_WAIT;
                ST_PD_WAIT: if (dly_q == TW'(PD_WAIT_T - 1)) state_d = ST_PD_DRIVE;
                ST_PD_DRIVE: if (dly_q == TW'(PD_LEN_T - 1)) state_d = ST_CMD;
                ST_CMD: begin
                    if (sample_stb && cmd_cnt_q == 3'd7) begin
                        if (cmd_word == CMD_READ_A || cmd_word == CMD_READ_B) begin
                            state_d = ST_READ;
                        end else if (cmd_word == CMD_SEARCH) begin
                            state_d = ST_SRCH_BIT;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_READ: if (sample_stb && bit_idx_q == IDX_W'(ID_W - 1)) state_d = ST_IDLE;
                ST_SRCH_BIT: if (sample_stb) state_d = ST_SRCH_CMP;
                ST_SRCH_CMP: if (sample_stb) state_d = ST_SRCH_DIR;
                ST_SRCH_DIR: begin
                    if (sample_stb) begin
                        if (line_s != own_bit || bit_idx_q == IDX_W'(ID_W - 1)) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_SRCH_BIT;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Delay counter, command shifter and identity bit index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q     <= '0;
            cmd_sr_q  <= '0;
            cmd_cnt_q <= '0;
            bit_idx_q <= '0;
        end else begin
            if (state_d != state_q) begin
                dly_q <= '0;
            end else if (dly_q != '1) begin
                dly_q <= dly_q + 1'b1;
            end

            if (state_q != ST_CMD) begin
                cmd_cnt_q <= '0;
            end else if (sample_stb) begin
                cmd_sr_q  <= cmd_word;
                cmd_cnt_q <= cmd_cnt_q + 1'b1;
            end

            if (state_q == ST_CMD) begin
                bit_idx_q <= '0;
            end else if (sample_stb && !rst_long &&
                         ((state_q == ST_READ) ||
                          (state_q == ST_SRCH_DIR && line_s == own_bit))) begin
                bit_idx_q <= bit_idx_q + 1'b1;
            end
        end
    end

    // Output logic: presence pulse, or a zero bit held inside the hold window.
    always_comb begin
        unique case (state_q)
            ST_PD_DRIVE: pull_low_o = 1'b1;
            ST_READ, ST_SRCH_BIT, ST_SRCH_CMP: pull_low_o = hold_win && !own_bit;
            default: pull_low_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ow_id_slave_chk.sv
module ow_id_slave_chk
    import ow_id_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input logic      clk,
    input logic      rst_n,
    input logic      line_s,
    input logic      rst_long,
    input logic      sample_stb,
    input logic      own_bit,
    input logic      pull_low_o,
    input ow_state_e state_q,
    input logic [5:0] bit_idx_q
);

    localparam int PD_LEN_T = us_ticks(CLK_HZ, 120);
    localparam int RW       = $clog2(PD_LEN_T + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!pull_low_o) begin
            run_q <= '0;
        end else if (run_q != RW'(PD_LEN_T + 1)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R2: no pull-low stretch lasts longer than the presence pulse
    a_r2_presence_cap: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(PD_LEN_T));

    // R1: while the reset low lasts, the block does not drive
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RESET |-> !pull_low_o);

    // R6: the silent state never drives
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !pull_low_o);

    // R9: a long low always lands in the reset state
    a_r9_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rst_long |=> state_q == ST_RESET);

    // R7: after sending the bit, the complement follows
    a_r7_bit_then_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRCH_BIT && sample_stb && !rst_long) |=> state_q == ST_SRCH_CMP);

    // R8: a mismatching direction bit drops the block out
    a_r8_dropout: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRCH_DIR && sample_stb && !rst_long && line_s != own_bit)
        |=> state_q == ST_IDLE);

    // R4: the bit index only moves on a slot's sample point
    a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && !sample_stb) |=> $stable(bit_idx_q));

endmodule

bind ow_id_slave ow_id_slave_chk #(.CLK_HZ(CLK_HZ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_s    (line_s),
    .rst_long  (rst_long),
    .sample_stb(sample_stb),
    .own_bit   (own_bit),
    .pull_low_o(pull_low_o),
    .state_q   (state_q),
    .bit_idx_q (bit_idx_q)
);

// File: tb/ow_id_slave_tb.sv
module ow_id_slave_tb;

    localparam int          CLK_HZ = 2_000_000;
    localparam int          TPU    = CLK_HZ / 1_000_000;
    localparam logic [63:0] ROM    = 64'h5C19_E47A_03B6_D201;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic pull;
    logic line;

    assign line = !(m_low || pull);
    always #10 clk = ~clk;

    ow_id_slave #(.CLK_HZ(CLK_HZ), .ROM_ID(ROM)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line),
        .pull_low_o(pull)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int i);
        return ROM[i];
    endfunction

    task automatic wait_us(input int us);
        repeat (us * TPU) @(negedge clk);
    endtask

    task automatic bus_reset(input int low_us, input bit pres, input string req);
        m_low = 1'b1; wait_us(low_us); m_low = 1'b0;
        wait_us(15);  check(req, 64'(line), 64'd1, "line before presence");
        wait_us(55);  check(req, 64'(line), pres ? 64'd0 : 64'd1, "presence at 70us");
        wait_us(130); check(req, 64'(line), 64'd1, "line after presence");
        wait_us(280);
    endtask

    task automatic write_bit(input logic b);
        int lo, rec;
        lo  = b ? 2 + int'($urandom_range(8)) : 62 + int'($urandom_range(28));
        rec = 2 + int'($urandom_range(4));
        m_low = 1'b1; wait_us(lo); m_low = 1'b0;
        if (lo < 70) wait_us(70 - lo);
        wait_us(rec);
    endtask

    task automatic write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    task automatic read_bit(output logic b, output logic late);
        int lo;
        lo = 3 + int'($urandom_range(2));
        m_low = 1'b1; wait_us(lo); m_low = 1'b0;
        wait_us(12 - lo); b = line;
        wait_us(13);      late = line;
        wait_us(40 + int'($urandom_range(4)));
    endtask

    task automatic read_rom(input int n, input string req);
        logic b, late;
        for (int i = 0; i < n; i++) begin
            read_bit(b, late);
            check(req, 64'(b), 64'(exp_bit(i)), $sformatf("identity bit %0d", i));
            if (!exp_bit(i)) check("R5", 64'(late), 64'd1, "line released at 25us");
        end
    endtask

    task automatic expect_silent(input int n, input string req);
        logic b, late;
        for (int i = 0; i < n; i++) begin
            read_bit(b, late);
            check(req, 64'(b), 64'd1, "released slot");
        end
    endtask

    task automatic search(input int stop_at, input string req);
        logic b, c, late;
        for (int i = 0; i < 64; i++) begin
            read_bit(b, late);
            read_bit(c, late);
            check(req, 64'(b), 64'(exp_bit(i)), $sformatf("search bit %0d", i));
            check(req, 64'(c), 64'(!exp_bit(i)), $sformatf("search complement %0d", i));
            if (i == stop_at) begin
                write_bit(!exp_bit(i));
                return;
            end
            write_bit(exp_bit(i));
        end
    endtask

    initial begin
        logic b, late;
        logic [7:0] rc;
        int k;
        void'($urandom(32'd7351));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", 64'(pull), 64'd0, "pull after reset");
        read_bit(b, late);
        check("R1", 64'(b), 64'd1, "slot without any bus reset");

        bus_reset(400, 1'b0, "R1");
        expect_silent(2, "R1");

        // 33h read, then silence after the last bit
        bus_reset(490, 1'b1, "R2");
        write_byte(8'h33);
        read_rom(64, "R4");
        expect_silent(4, "R10");

        // match and skip codes
        bus_reset(490, 1'b1, "R2");
        write_byte(8'h55);
        expect_silent(8, "R6");
        bus_reset(490, 1'b1, "R2");
        write_byte(8'hCC);
        expect_silent(8, "R6");

        // random code outside the decoded set
        do rc = 8'($urandom); while (rc == 8'h33 || rc == 8'h0F || rc == 8'hF0);
        bus_reset(490, 1'b1, "R2");
        write_byte(rc);
        expect_silent(8, "R6");

        // full search pass
        bus_reset(490, 1'b1, "R2");
        write_byte(8'hF0);
        search(64, "R7");
        expect_silent(2, "R10");

        // search with a wrong direction at a random bit
        k = int'($urandom_range(31));
        bus_reset(490, 1'b1, "R2");
        write_byte(8'hF0);
        search(k, "R7");
        expect_silent(4, "R8");

        // reset in the middle of a read, then 0Fh read
        bus_reset(490, 1'b1, "R2");
        write_byte(8'h33);
        read_rom(20, "R4");
        bus_reset(490, 1'b1, "R9");
        write_byte(8'h0F);
        read_rom(64, "R3");
        check("R9", 64'(pull), 64'd0, "released after restarted read");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all R): got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule